// File: doc/BRIEF.md
# Auxiliary UART Register Front End

This block is the processor-facing side of a simplified auxiliary serial port. Software reaches it with 32-bit accesses over a 256-byte window. Bytes that arrive from the line side come in on a byte stream with a valid/ready handshake. They are held in a circular receive queue, and software drains them through the data register. A byte that software writes to the data register leaves at once as a one-cycle pulse on the transmit byte stream. Because of this, the transmit side always reports itself empty and idle.

The block builds the interrupt identification, line status and extended status words from the queue fill level and two interrupt enables, and it drives one interrupt line. Line control, modem control, modem status, scratch and baud locations read as zero and ignore writes. Read data is registered and appears one cycle after the request.

Top module: `auxuart_regif`

## Requirements
- R1: Fixed locations: offset 0x04 reads 1 and offset 0x60 reads 0x3. Offsets 0x4C, 0x50, 0x58, 0x5C, 0x68 and any unmapped offset read 0. Writes to these locations change no observable state.
- R2: A write to offset 0x44 stores only bits [1:0], where bit 0 enables the transmit interrupt and bit 1 enables the receive interrupt. A read of 0x44 returns 0xC0 ORed with the stored bits.
- R3: `irq` is high when the transmit enable is set, or when the receive enable is set and the queue is not empty. Otherwise it is low.
- R4: Offset 0x48 reads 0xC0 plus 0x4 if the queue holds data, or 0x2 if it is empty, with bit 0 also set when `irq` is low.
- R5: A write to offset 0x48 with bit 1 set empties the queue. With bit 1 clear the write has no effect.
- R6: A read of offset 0x40 returns the byte at the head of the queue, then removes it. A read of 0x40 on an empty queue returns the byte left at the head position and leaves the fill count at 0.
- R7: `rx_ready` is high exactly while the fill count is below DEPTH (default 8). Bytes come out in arrival order across pointer wrap-around, and a byte offered while the queue is full is not taken.
- R8: Offset 0x54 reads 0x60, with bit 0 set when the queue is not empty.
- R9: Offset 0x64 reads 0x30E, with bit 0 set when the queue is not empty and the fill count in bits [19:16].
- R10: Offset 0x00 reads 1 when `irq` is high, else 0.
- R11: A write to offset 0x40 gives `tx_valid` high for exactly one cycle, starting the cycle after the request, with `tx_data` equal to wdata[7:0].
- R12: After reset the fill count and both enables are 0. `irq` is low and `rx_ready` is high.
- R13: `rsp_valid` is high for one cycle, the cycle after each read request, and `rsp_rdata` carries the read value in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Queue can take a byte |
| tx_valid | output | 1 | Outgoing byte pulse |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check, on every cycle, several things: the fill-count bound, that a full queue drops ready, the one-cycle decrement on a data read, that a flush leaves at most one byte, and the transmit pulse and read-response timing after each access. They also check that setting the transmit enable raises the interrupt. Only the bench scenarios can show data order across pointer wrap-around, the stale byte returned by an empty read, and the exact status and identification words at each fill level. The same holds for the silence of the unused locations and for the state after a reset taken in the middle of a run.

// File: rtl/auxuart_pkg.sv
package auxuart_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTE_W = 8;

    localparam logic [ADDR_W-1:0] OFF_IRQSUM = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_ENA    = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_DATA   = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_IEN    = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_IID    = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_LSTAT  = 8'h54;
    localparam logic [ADDR_W-1:0] OFF_XCTL   = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_XSTAT  = 8'h64;

    localparam int unsigned IEN_TX_BIT = 0;
    localparam int unsigned IEN_RX_BIT = 1;
    localparam int unsigned IID_FLUSH_BIT = 1;

    localparam logic [WORD_W-1:0] FIFO_ON_BITS = 32'h0000_00C0;
    localparam logic [WORD_W-1:0] LSTAT_BASE   = 32'h0000_0060;
    localparam logic [WORD_W-1:0] XSTAT_BASE   = 32'h0000_030E;
    localparam int unsigned       XSTAT_LVL_LSB = 16;

endpackage

// File: rtl/auxuart_rxq.sv
module auxuart_rxq #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [7:0]       push_byte,
    input  logic             pop,
    input  logic             flush,
    output logic [7:0]       head_byte,
    output logic [CNT_W-1:0] level,
    output logic             full
);
    localparam int unsigned SUM_W = ((PTR_W > CNT_W) ? PTR_W : CNT_W) + 1;

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [CNT_W-1:0] cnt;
    } q_state_t;

    q_state_t         st_q, st_d;
    logic [7:0]       slots_q [DEPTH];
    logic [SUM_W-1:0] tail_sum;
    logic [PTR_W-1:0] tail_idx;
    logic [PTR_W-1:0] wr_idx;
    logic             pop_ok;

    always_comb begin
        tail_sum = SUM_W'(st_q.head) + SUM_W'(st_q.cnt);
        if (tail_sum >= SUM_W'(DEPTH)) begin
            tail_idx = PTR_W'(tail_sum - SUM_W'(DEPTH));
        end else begin
            tail_idx = PTR_W'(tail_sum);
        end
        wr_idx = flush ? st_q.head : tail_idx;
        pop_ok = pop && (st_q.cnt != '0);

        st_d = st_q;
        if (flush) begin
            st_d.cnt = push ? CNT_W'(1) : '0;
        end else begin
            if (pop_ok) begin
                if (st_q.head == PTR_W'(DEPTH - 1)) begin
                    st_d.head = '0;
                end else begin
                    st_d.head = st_q.head + PTR_W'(1);
                end
            end
            st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slots_q[wr_idx] <= push_byte;
        end
    end

    assign head_byte = slots_q[st_q.head];
    assign level     = st_q.cnt;
    assign full      = (st_q.cnt == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R7
    AST_HEAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.head) < DEPTH); // R7

endmodule

// File: rtl/auxuart_rdmux.sv
module auxuart_rdmux
    import auxuart_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  level,
    input  logic [1:0]        ien,
    input  logic              irq_now,
    input  logic [7:0]        head_byte,
    output logic [WORD_W-1:0] word
);
    logic has_data;

    always_comb begin
        has_data = (level != '0);
        word     = '0;
        unique case (addr)
            OFF_IRQSUM: word = WORD_W'(irq_now);
            OFF_ENA:    word = 32'h1;
            OFF_DATA:   word = WORD_W'(head_byte);
            OFF_IEN:    word = FIFO_ON_BITS | WORD_W'(ien);
            OFF_IID:    word = FIFO_ON_BITS
                             | (has_data ? 32'h4 : 32'h2)
                             | WORD_W'(!irq_now);
            OFF_LSTAT:  word = LSTAT_BASE | WORD_W'(has_data);
            OFF_XCTL:   word = 32'h3;
            OFF_XSTAT:  word = XSTAT_BASE | WORD_W'(has_data)
                             | (WORD_W'(level) << XSTAT_LVL_LSB);
            default:    word = '0;
        endcase
    end

endmodule

// File: rtl/auxuart_regif.sv
module auxuart_regif
    import auxuart_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [1:0]        ien;
        logic              rsp_v;
        logic [WORD_W-1:0] rsp_w;
        logic              tx_v;
        logic [7:0]        tx_b;
    } top_state_t;

    top_state_t        st_q, st_d;
    logic              acc_wr, acc_rd;
    logic              do_pop, do_flush, do_push;
    logic [7:0]        head_byte;
    logic [CNT_W-1:0]  level;
    logic              q_full;
    logic [WORD_W-1:0] rd_word;
    logic              irq_now;

    assign acc_wr   = req_valid && req_write;
    assign acc_rd   = req_valid && !req_write;
    assign do_pop   = acc_rd && (req_addr == OFF_DATA);
    assign do_flush = acc_wr && (req_addr == OFF_IID) && req_wdata[IID_FLUSH_BIT];
    assign do_push  = rx_valid && !q_full;

    assign irq_now = st_q.ien[IEN_TX_BIT]
                   || (st_q.ien[IEN_RX_BIT] && (level != '0));

    auxuart_rxq #(.DEPTH(DEPTH)) rxq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .push_byte (rx_data),
        .pop       (do_pop),
        .flush     (do_flush),
        .head_byte (head_byte),
        .level     (level),
        .full      (q_full)
    );

    auxuart_rdmux #(.CNT_W(CNT_W)) rdmux_i (
        .addr      (req_addr),
        .level     (level),
        .ien       (st_q.ien),
        .irq_now   (irq_now),
        .head_byte (head_byte),
        .word      (rd_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = acc_rd;
        st_d.tx_v  = 1'b0;
        if (acc_rd) begin
            st_d.rsp_w = rd_word;
        end
        if (acc_wr) begin
            unique case (req_addr)
                OFF_IEN:  st_d.ien = req_wdata[1:0];
                OFF_DATA: begin
                    st_d.tx_v = 1'b1;
                    st_d.tx_b = req_wdata[7:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_rdata = st_q.rsp_w;
    assign tx_valid  = st_q.tx_v;
    assign tx_data   = st_q.tx_b;
    assign rx_ready  = !q_full;
    assign irq       = irq_now;

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CNT_W'(DEPTH)) |-> !rx_ready); // R7
    AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && level != '0 && !rx_valid) |=> (level == $past(level) - CNT_W'(1))); // R6
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && level == '0 && !rx_valid) |=> (level == '0)); // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        do_flush |=> (level <= CNT_W'(1))); // R5
    AST_TX_ENA_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && req_addr == OFF_IEN && req_wdata[IEN_TX_BIT]) |=> irq); // R3
    AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && req_addr == OFF_DATA) |=> (tx_valid && tx_data == $past(req_wdata[7:0]))); // R11
    AST_TX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && req_addr == OFF_DATA) |=> !tx_valid); // R11
    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rsp_valid); // R13
    AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> !rsp_valid); // R13

endmodule

// File: tb/auxuart_regif_tb.sv
module auxuart_regif_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    auxuart_regif #(.DEPTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    // {offset, expected read value} right after reset
    localparam logic [39:0] VEC [13] = '{
        {8'h00, 32'h0000_0000},   // R10
        {8'h04, 32'h0000_0001},   // R1
        {8'h44, 32'h0000_00C0},   // R2
        {8'h48, 32'h0000_00C3},   // R4
        {8'h4C, 32'h0000_0000},   // R1
        {8'h50, 32'h0000_0000},   // R1
        {8'h54, 32'h0000_0060},   // R8
        {8'h58, 32'h0000_0000},   // R1
        {8'h5C, 32'h0000_0000},   // R1
        {8'h60, 32'h0000_0003},   // R1
        {8'h64, 32'h0000_030E},   // R9
        {8'h68, 32'h0000_0000},   // R1
        {8'hA0, 32'h0000_0000}    // R1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic rx_push(input logic [7:0] b, output logic taken);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        taken = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] r;
        logic        tk;
        do_reset();

        // R12 reset state
        chk("R12 irq", 32'(irq), 32'h0);
        chk("R12 rx_ready", 32'(rx_ready), 32'h1);

        for (int i = 0; i < 13; i++) begin
            bus_rd(VEC[i][39:32], r);
            chk($sformatf("R1/R2/R4/R8/R9/R10 vec%0d", i), r, VEC[i][31:0]);
        end

        // R13 response timing
        bus_rd(8'h04, r);
        chk("R13 rsp_valid", 32'(rsp_valid), 32'h1);
        @(negedge clk);
        chk("R13 rsp_valid drop", 32'(rsp_valid), 32'h0);

        // R2 / R3 / R4 / R10 transmit enable
        bus_wr(8'h44, 32'hFFFF_FFFD);
        chk("R3 irq tx enable", 32'(irq), 32'h1);
        bus_rd(8'h44, r);  chk("R2 mask", r, 32'h0000_00C1);
        bus_rd(8'h48, r);  chk("R4 pending empty", r, 32'h0000_00C2);
        bus_rd(8'h00, r);  chk("R10 summary", r, 32'h1);
        bus_wr(8'h44, 32'h0);
        chk("R3 irq off", 32'(irq), 32'h0);

        // R1 writes to unused locations ignored
        bus_wr(8'h4C, 32'hFFFF_FFFF);
        bus_wr(8'h5C, 32'hA5A5_A5A5);
        bus_wr(8'h60, 32'h0);
        bus_wr(8'h04, 32'h0);
        bus_rd(8'h5C, r);  chk("R1 scratch", r, 32'h0);
        bus_rd(8'h60, r);  chk("R1 xctl", r, 32'h3);
        bus_rd(8'h04, r);  chk("R1 enables", r, 32'h1);
        bus_rd(8'h44, r);  chk("R1 ien untouched", r, 32'hC0);

        // R11 transmit pulse
        bus_wr(8'h40, 32'h0000_01A5);
        chk("R11 tx_valid", 32'(tx_valid), 32'h1);
        chk("R11 tx_data", 32'(tx_data), 32'hA5);
        @(negedge clk);
        chk("R11 pulse width", 32'(tx_valid), 32'h0);

        // three bytes in, status words, drain (head ends at slot 3)
        rx_push(8'h11, tk); rx_push(8'h22, tk); rx_push(8'h33, tk);
        bus_rd(8'h54, r);  chk("R8 nonempty", r, 32'h61);
        bus_rd(8'h64, r);  chk("R9 level 3", r, 32'h0003_030F);
        bus_rd(8'h48, r);  chk("R4 data no irq", r, 32'hC5);
        chk("R3 rx disabled", 32'(irq), 32'h0);
        bus_wr(8'h44, 32'h2);
        chk("R3 rx enabled", 32'(irq), 32'h1);
        bus_rd(8'h48, r);  chk("R4 data irq", r, 32'hC4);
        bus_rd(8'h40, r);  chk("R6 byte0", r, 32'h11);
        bus_rd(8'h40, r);  chk("R6 byte1", r, 32'h22);
        bus_rd(8'h40, r);  chk("R6 byte2", r, 32'h33);
        chk("R3 rx empty", 32'(irq), 32'h0);

        // R7 fill to depth across wrap
        for (int i = 0; i < 8; i++) begin
            rx_push(8'h50 + 8'(i), tk);
            chk("R7 accept", 32'(tk), 32'h1);
        end
        chk("R7 ready low full", 32'(rx_ready), 32'h0);
        rx_push(8'hEE, tk);
        chk("R7 refused", 32'(tk), 32'h0);
        bus_rd(8'h64, r);  chk("R9 level 8", r, 32'h0008_030F);
        for (int i = 0; i < 8; i++) begin
            bus_rd(8'h40, r);
            chk("R7 order", r, 32'h50 + 32'(i));
        end
        chk("R7 ready again", 32'(rx_ready), 32'h1);
        // R6 empty read: stale head (slot 3 held 0x50), count stays 0
        bus_rd(8'h40, r);  chk("R6 stale", r, 32'h50);
        bus_rd(8'h64, r);  chk("R6 still empty", r, 32'h30E);

        // R5 flush
        rx_push(8'h61, tk); rx_push(8'h62, tk);
        bus_wr(8'h48, 32'h1);
        bus_rd(8'h64, r);  chk("R5 no flush bit1 clear", r, 32'h0002_030F);
        bus_wr(8'h48, 32'h2);
        bus_rd(8'h64, r);  chk("R5 flushed", r, 32'h30E);
        bus_rd(8'h54, r);  chk("R5 lstat empty", r, 32'h60);

        // R12 reset mid-run
        rx_push(8'h71, tk);
        bus_wr(8'h44, 32'h3);
        do_reset();
        chk("R12 irq after reset", 32'(irq), 32'h0);
        bus_rd(8'h64, r);  chk("R12 level", r, 32'h30E);
        bus_rd(8'h44, r);  chk("R12 ien", r, 32'hC0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule